// File: doc/BRIEF.md
# Trace Execution Frequency Filter

This block counts how often each trace identifier is executed and signals once, when an identifier has been seen a programmed number of times. It keeps a small set-associative table of tagged counters. Every lookup presents an identifier. A resident identifier has its counter advanced, and an unknown identifier claims a slot with a count of one. When the count equals the programmed threshold, the block emits a single-cycle promote pulse that carries the identifier.

The same block serves two roles. In one, a promote event starts building a trace from a frequently seen path. In the other, it sends an already cached trace to optimization and write-back. The two roles differ only in the threshold they program. A threshold of zero means infinity: no promote event is ever raised. When a set is full, a miss replaces the least recently used slot, and the victim's count is discarded.

With the default parameters the table has 128 sets of 8 ways (1024 slots), takes 32-bit identifiers, and uses 15-bit counters, so thresholds up to 32767 are possible.

Top module: `trace_freq_filter`

## Requirements
- R1: A lookup of an identifier that is resident in the table raises its count by one. A count that has reached all-ones stays there.
- R2: A lookup of an identifier that is not resident places it in the table with a count of one. With a threshold of 1, that first lookup promotes.
- R3: The promote pulse is high for exactly the one cycle after the clock edge that accepted the lookup whose new count equals the threshold. During that cycle the identifier output holds that lookup's identifier.
- R4: An identifier that has already promoted does not promote again while it stays resident, no matter how many further lookups it gets.
- R5: When the threshold input is 0, no promote pulse is raised and counting continues.
- R6: A cycle with the lookup valid input low changes no count, no recency order, and no residency. The cycle after it shows no promote.
- R7: A miss into a set whose 8 ways are all occupied evicts the least recently looked-up identifier of that set. A later lookup of the evicted identifier starts again at a count of one.
- R8: Both hits and allocations make the touched identifier the most recently used in its set, which protects it from the next eviction.
- R9: While a set still has unoccupied ways, a miss fills a free way and evicts nothing.
- R10: The set is selected by the low 7 bits of the identifier, and the remaining upper bits are stored as the tag. Identifiers in different sets never evict one another.
- R11: After reset the table is empty and the promote output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid_i | input | 1 | A lookup is presented this cycle |
| lk_id_i | input | ID_W (32) | Trace identifier of the lookup |
| thr_i | input | CNT_W (15) | Promote threshold; 0 means never promote |
| prom_valid_o | output | 1 | One-cycle promote event |
| prom_id_o | output | ID_W (32) | Identifier that reached the threshold |

## Verification
The table is read and updated in the same cycle, and only the promote output is registered. Each lookup's promote result therefore appears after exactly one rising edge, and a lookup in the following cycle already sees the updated count and recency. The bench applies a lookup at a falling edge and reads the promote output at the next falling edge, which is the cycle that lookup owns. This allows lookups to run back to back with no gaps. Each expected result comes from a reference model of per-set recency queues with associative counters. The model is stepped at the same point, so the checks hold under repeated, filling, evicting and thrashing identifier streams.

// File: rtl/ffilt_pkg.sv
package ffilt_pkg;

    localparam int unsigned DEF_ID_W  = 32;
    localparam int unsigned DEF_SETS  = 128;
    localparam int unsigned DEF_WAYS  = 8;
    localparam int unsigned DEF_CNT_W = 15;

    // Outcome of one lookup against its set.
    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_HIT   = 2'd1,
        LK_FILL  = 2'd2,
        LK_EVICT = 2'd3
    } lk_kind_e;

endpackage

// File: rtl/ffilt_way_match.sv
module ffilt_way_match #(
    parameter int unsigned WAYS  = 8,
    parameter int unsigned TAG_W = 25,
    localparam int unsigned AGE_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]       vld_i,
    input  logic [WAYS*TAG_W-1:0] tags_i,
    input  logic [WAYS*AGE_W-1:0] ages_i,
    input  logic [TAG_W-1:0]      tag_i,
    output logic                  hit_o,
    output logic [AGE_W-1:0]      hit_way_o,
    output logic                  free_o,
    output logic [AGE_W-1:0]      fill_way_o
);

    logic [WAYS-1:0]  match;
    logic [WAYS-1:0]  oldest;
    logic [AGE_W-1:0] free_way;
    logic [AGE_W-1:0] lru_way;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            assign match[w]  = vld_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i);
            assign oldest[w] = (ages_i[w*AGE_W +: AGE_W] == AGE_W'(WAYS - 1));
        end
    endgenerate

    // Lowest index wins in each encoder.
    always_comb begin
        hit_way_o = '0;
        lru_way   = '0;
        free_way  = '0;
        free_o    = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way_o = AGE_W'(w);
            if (oldest[w]) lru_way = AGE_W'(w);
            if (!vld_i[w]) begin
                free_o   = 1'b1;
                free_way = AGE_W'(w);
            end
        end
    end

    assign hit_o      = |match;
    assign fill_way_o = free_o ? free_way : lru_way;

endmodule

// File: rtl/ffilt_age_update.sv
module ffilt_age_update #(
    parameter int unsigned WAYS = 8,
    localparam int unsigned AGE_W = $clog2(WAYS)
) (
    input  logic [WAYS*AGE_W-1:0] ages_i,
    input  logic [AGE_W-1:0]      touch_i,
    output logic [WAYS*AGE_W-1:0] ages_o
);

    logic [AGE_W-1:0] touched_age;

    always_comb begin
        touched_age = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (touch_i == AGE_W'(w)) touched_age = ages_i[w*AGE_W +: AGE_W];
        end
    end

    // Ages form a permutation: touched way becomes 0, younger ways age by one.
    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_age
            logic [AGE_W-1:0] cur;
            assign cur = ages_i[w*AGE_W +: AGE_W];
            assign ages_o[w*AGE_W +: AGE_W] =
                (touch_i == AGE_W'(w)) ? '0 :
                (cur < touched_age)    ? cur + AGE_W'(1) : cur;
        end
    endgenerate

endmodule

// File: rtl/ffilt_count_step.sv
module ffilt_count_step #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             fresh_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             fired_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fired_o,
    output logic             promote_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] bumped;
    logic             base_fired;

    assign base       = fresh_i ? '0 : cnt_i;
    assign base_fired = fresh_i ? 1'b0 : fired_i;
    assign bumped     = (base == CNT_MAX) ? base : base + CNT_W'(1);

    assign promote_o = !base_fired && (thr_i != '0) && (bumped == thr_i);
    assign cnt_o     = base_fired ? base : bumped;
    assign fired_o   = base_fired | promote_o;

endmodule

// File: rtl/trace_freq_filter.sv
module trace_freq_filter
    import ffilt_pkg::*;
#(
    parameter int unsigned ID_W  = DEF_ID_W,
    parameter int unsigned SETS  = DEF_SETS,
    parameter int unsigned WAYS  = DEF_WAYS,
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_valid_i,
    input  logic [ID_W-1:0]  lk_id_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             prom_valid_o,
    output logic [ID_W-1:0]  prom_id_o
);

    localparam int unsigned SET_W = $clog2(SETS);
    localparam int unsigned TAG_W = ID_W - SET_W;
    localparam int unsigned AGE_W = $clog2(WAYS);

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [CNT_W-1:0] cnt;
        logic             fired;
    } slot_t;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
    } prom_t;

    slot_t            slot_q [SETS][WAYS];
    logic [WAYS-1:0]  vld_q  [SETS];
    logic [AGE_W-1:0] age_q  [SETS][WAYS];
    prom_t            prom_q;
    prom_t            prom_n;

    logic [SET_W-1:0]       set_idx;
    logic [TAG_W-1:0]       tag;
    logic [WAYS*TAG_W-1:0]  row_tags;
    logic [WAYS*AGE_W-1:0]  row_ages;
    logic [WAYS*AGE_W-1:0]  row_ages_n;
    logic [WAYS-1:0]        row_vld;

    logic             hit;
    logic             has_free;
    logic [AGE_W-1:0] hit_way;
    logic [AGE_W-1:0] fill_way;
    logic [AGE_W-1:0] sel_way;
    lk_kind_e         kind;
    slot_t            sel_slot;
    slot_t            new_slot;
    logic [CNT_W-1:0] cnt_n;
    logic             fired_n;
    logic             promote;

    assign set_idx = lk_id_i[SET_W-1:0];
    assign tag     = lk_id_i[ID_W-1:SET_W];

    always_comb begin
        row_vld = vld_q[set_idx];
        for (int w = 0; w < WAYS; w++) begin
            row_tags[w*TAG_W +: TAG_W] = slot_q[set_idx][w].tag;
            row_ages[w*AGE_W +: AGE_W] = age_q[set_idx][w];
        end
    end

    ffilt_way_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) match_i (
        .vld_i      (row_vld),
        .tags_i     (row_tags),
        .ages_i     (row_ages),
        .tag_i      (tag),
        .hit_o      (hit),
        .hit_way_o  (hit_way),
        .free_o     (has_free),
        .fill_way_o (fill_way)
    );

    always_comb begin
        if (!lk_valid_i)   kind = LK_IDLE;
        else if (hit)      kind = LK_HIT;
        else if (has_free) kind = LK_FILL;
        else               kind = LK_EVICT;
    end

    assign sel_way  = (kind == LK_HIT) ? hit_way : fill_way;
    assign sel_slot = slot_q[set_idx][sel_way];

    ffilt_count_step #(
        .CNT_W (CNT_W)
    ) count_i (
        .fresh_i   (kind != LK_HIT),
        .cnt_i     (sel_slot.cnt),
        .fired_i   (sel_slot.fired),
        .thr_i     (thr_i),
        .cnt_o     (cnt_n),
        .fired_o   (fired_n),
        .promote_o (promote)
    );

    ffilt_age_update #(
        .WAYS (WAYS)
    ) age_i (
        .ages_i  (row_ages),
        .touch_i (sel_way),
        .ages_o  (row_ages_n)
    );

    assign new_slot = '{tag: tag, cnt: cnt_n, fired: fired_n};
    assign prom_n   = '{valid: lk_valid_i && promote, id: lk_id_i};

    // Residency, recency and the output event are reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            prom_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= AGE_W'(w);
                end
            end
        end else begin
            prom_q <= prom_n;
            if (kind != LK_IDLE) begin
                vld_q[set_idx][sel_way] <= 1'b1;
                for (int w = 0; w < WAYS; w++) begin
                    age_q[set_idx][w] <= row_ages_n[w*AGE_W +: AGE_W];
                end
            end
        end
    end

    // Slot payload is only meaningful under its valid bit.
    always_ff @(posedge clk) begin
        if (!rst && kind != LK_IDLE) begin
            slot_q[set_idx][sel_way] <= new_slot;
        end
    end

    assign prom_valid_o = prom_q.valid;
    assign prom_id_o    = prom_q.id;

endmodule

// File: rtl/ffilt_checker.sv
module ffilt_checker #(
    parameter int unsigned ID_W  = 32,
    parameter int unsigned CNT_W = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid_i,
    input logic [ID_W-1:0]  lk_id_i,
    input logic [CNT_W-1:0] thr_i,
    input logic             prom_valid_o,
    input logic [ID_W-1:0]  prom_id_o
);

    assert_prom_after_lookup_R3: assert property (@(posedge clk) disable iff (rst)
        prom_valid_o |-> $past(lk_valid_i));

    assert_prom_carries_id_R3: assert property (@(posedge clk) disable iff (rst)
        prom_valid_o |-> (prom_id_o == $past(lk_id_i)));

    assert_no_repeat_promote_R4: assert property (@(posedge clk) disable iff (rst)
        (prom_valid_o && lk_valid_i && lk_id_i == prom_id_o) |=> !prom_valid_o);

    assert_zero_thr_silent_R5: assert property (@(posedge clk) disable iff (rst)
        prom_valid_o |-> ($past(thr_i) != '0));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !lk_valid_i |=> !prom_valid_o);

    assert_reset_quiet_R11: assert property (@(posedge clk)
        rst |=> !prom_valid_o);

endmodule

bind trace_freq_filter ffilt_checker #(
    .ID_W  (ID_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .lk_valid_i   (lk_valid_i),
    .lk_id_i      (lk_id_i),
    .thr_i        (thr_i),
    .prom_valid_o (prom_valid_o),
    .prom_id_o    (prom_id_o)
);

// File: tb/trace_freq_filter_tb.sv
module trace_freq_filter_tb_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned ID_W       = 32;
    localparam int unsigned SETS       = 128;
    localparam int unsigned WAYS       = 8;
    localparam int unsigned CNT_W      = 15;
    localparam int unsigned CNT_MAX    = (1 << CNT_W) - 1;
    localparam int unsigned WD_CYCLES  = 150000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             lk_valid = 1'b0;
    logic [ID_W-1:0]  lk_id = '0;
    logic [CNT_W-1:0] thr = '0;
    logic             prom_valid;
    logic [ID_W-1:0]  prom_id;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trace_freq_filter #(
        .ID_W  (ID_W),
        .SETS  (SETS),
        .WAYS  (WAYS),
        .CNT_W (CNT_W)
    ) dut_i (
        .clk          (clk),
        .rst          (rst),
        .lk_valid_i   (lk_valid),
        .lk_id_i      (lk_id),
        .thr_i        (thr),
        .prom_valid_o (prom_valid),
        .prom_id_o    (prom_id)
    );

    // Reference: per-set recency queue (front = most recent) plus counters.
    logic [ID_W-1:0] m_ways [SETS][$];
    int unsigned     m_cnt  [logic [ID_W-1:0]];
    bit              m_done [logic [ID_W-1:0]];

    function automatic void model_clear();
        for (int s = 0; s < SETS; s++) m_ways[s].delete();
        m_cnt.delete();
        m_done.delete();
    endfunction

    function automatic bit model_step(logic [ID_W-1:0] id, int unsigned t);
        int              s;
        int              pos;
        logic [ID_W-1:0] victim;
        s   = int'(id % SETS);
        pos = -1;
        for (int i = 0; i < m_ways[s].size(); i++) if (m_ways[s][i] == id) pos = i;
        if (pos >= 0) begin
            m_ways[s].delete(pos);
        end else begin
            if (m_ways[s].size() == WAYS) begin
                victim = m_ways[s].pop_back();
                m_cnt.delete(victim);
                m_done.delete(victim);
            end
            m_cnt[id]  = 0;
            m_done[id] = 1'b0;
        end
        m_ways[s].push_front(id);
        if (m_done[id]) return 1'b0;
        if (m_cnt[id] < CNT_MAX) m_cnt[id] = m_cnt[id] + 1;
        if (t != 0 && m_cnt[id] == t) begin
            m_done[id] = 1'b1;
            return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic act_v, input logic [ID_W-1:0] act_id,
                         input logic exp_v, input logic [ID_W-1:0] exp_id);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual valid=%0b id=%h, expected valid=%0b id=%h",
                     req, what, act_v, act_id, exp_v, exp_id);
        end
    endtask

    // Lookup at a falling edge; its result is due after the next rising edge.
    task automatic look(input logic [ID_W-1:0] id, input string req);
        bit exp;
        lk_valid = 1'b1;
        lk_id    = id;
        exp      = model_step(id, int'(thr));
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
        check(prom_valid == exp && (!exp || prom_id == id), req, "lookup",
              prom_valid, prom_id, exp, id);
    endtask

    task automatic idle(input logic [ID_W-1:0] id, input string req);
        lk_valid = 1'b0;
        lk_id    = id;
        @(posedge clk);
        @(negedge clk);
        check(prom_valid == 1'b0, req, "idle", prom_valid, prom_id, 1'b0, '0);
    endtask

    task automatic do_reset();
        lk_valid = 1'b0;
        rst      = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    function automatic logic [ID_W-1:0] mk_id(int unsigned upper, int unsigned set);
        return ID_W'((upper << 7) | (set & 32'h7f));
    endfunction

    task automatic t_reset_state();
        do_reset();
        check(prom_valid == 1'b0, "R11", "after reset", prom_valid, prom_id, 1'b0, '0);
    endtask

    task automatic t_first_lookup();
        do_reset();
        thr = 15'd1;
        look(32'hCAFE_0011, "R2");
        idle(32'hCAFE_0011, "R3");
        look(32'hCAFE_0011, "R4");
    endtask

    task automatic t_count_up();
        do_reset();
        thr = 15'd8;
        for (int i = 0; i < 12; i++) look(32'h1234_5600, (i < 8) ? "R1" : "R4");
        thr = 15'd512;
        for (int i = 0; i < 520; i++) look(32'h0BAD_F00D, "R1");
    endtask

    task automatic t_infinite();
        do_reset();
        thr = 15'd0;
        for (int i = 0; i < 40; i++) look(32'h0000_7777, "R5");
        thr = 15'd41;
        look(32'h0000_7777, "R5");
    endtask

    task automatic t_idle_gap();
        do_reset();
        thr = 15'd3;
        look(32'hA5A5_0003, "R6");
        look(32'hA5A5_0003, "R6");
        for (int i = 0; i < 5; i++) idle(32'hA5A5_0003, "R6");
        look(32'hA5A5_0003, "R6");
    endtask

    task automatic t_fill();
        do_reset();
        thr = 15'd2;
        for (int i = 0; i < WAYS; i++) look(mk_id(i + 1, 5), "R9");
        for (int i = 0; i < WAYS; i++) look(mk_id(i + 1, 5), "R9");
    endtask

    task automatic t_evict();
        do_reset();
        thr = 15'd2;
        for (int i = 0; i <= WAYS; i++) look(mk_id(i + 1, 9), "R7");
        look(mk_id(1, 9), "R7");
        look(mk_id(1, 9), "R7");
    endtask

    task automatic t_refresh();
        do_reset();
        thr = 15'd3;
        for (int i = 0; i < WAYS; i++) look(mk_id(i + 1, 20), "R8");
        look(mk_id(1, 20), "R8");
        look(mk_id(100, 20), "R8");
        look(mk_id(1, 20), "R8");
        look(mk_id(2, 20), "R8");
        look(mk_id(2, 20), "R8");
    endtask

    task automatic t_sets();
        do_reset();
        thr = 15'd2;
        for (int i = 0; i < 16; i++) look(mk_id(3, i), "R10");
        for (int i = 0; i < 16; i++) look(mk_id(4, i), "R10");
        for (int i = 0; i < 16; i++) look(mk_id(3, i), "R10");
    endtask

    task automatic t_thrash();
        logic [15:0] lf;
        do_reset();
        thr = 15'd3;
        lf  = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[15:13] == 3'b000) idle(mk_id(lf[3:0], lf[4]), "R6");
            else look(mk_id(32'(lf[3:0]) % 12, lf[4]), "R7");
        end
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        t_reset_state();
        t_first_lookup();
        t_count_up();
        t_infinite();
        t_idle_gap();
        t_fill();
        t_evict();
        t_refresh();
        t_sets();
        t_thrash();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule